// File: doc/BRIEF.md
# Dual-Input Proportional Fan PWM Generator

This block turns two digitized temperature or fan-demand codes into a slow pulse-width modulated fan-drive signal. Each input is an 8-bit code of a control voltage expressed as a fraction of supply. The larger of the two codes is mapped through an offset window to a duty value: a code at the window floor gives a stopped fan, a code at or above the window ceiling gives full drive, and codes in between scale linearly.

A free-running period counter advances on a slow time-base tick. One PWM period is 256 ticks. The duty value is captured when the counter wraps, and the output is high while the count is below the captured duty. Supervisory logic can hold the output high through a force input, for example during a fan spin-up interval. A low enable stops the output and parks the counter at zero. A one-clock strobe marks the start of each period so that other logic can count PWM periods.

Top module: `fan_pwm_gen`

## Requirements
- R1: The code that sets the duty is the larger of `code_a` and `code_b`. The result does not depend on which input carries the larger code, and equal codes give the same result as either code alone.
- R2: With `m` the selected code, the duty in 1/256 units is 0 for m <= 77, and floor((m - 77) * 256 / 102) for 77 < m < 179. Within a period, `pwm_out` is high in exactly as many counter states as the duty value.
- R3: For m >= 179 the duty is 256, and `pwm_out` stays high for the whole period with no low phase.
- R4: The counter advances by one only in clocks where `tick` is 1. A period spans 256 ticks, and `pwm_out` is high for (ticks per state) × duty clocks in each period.
- R5: The duty value is captured only at a counter wrap (or at any clock while `enable` is low). A code change partway through a period does not alter that period.
- R6: With `enable` high, `force_high` = 1 drives `pwm_out` high from the next clock, whatever the duty value. When it is released, the computed duty applies again from the next clock.
- R7: While `enable` is low, `pwm_out` is low from the next clock even when `force_high` is 1, and the counter is held at zero. After `enable` rises, the first `period_start` comes 256 ticks later. The first period uses the duty captured while the block was disabled.
- R8: `period_start` is registered. It is high for exactly one clock, in the clock after the edge at which the counter wraps from 255 to 0. `pwm_out` is registered and reflects the counter state shown in the same clock.
- R9: While `rst_n` is low, `pwm_out` and `period_start` are 0 and the counter and captured duty are zero. Reset is applied asynchronously, and its release is synchronized to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Time-base enable; the counter advances one step per clock with tick high |
| code_a | input | 8 | First control code (fraction of supply, 0..255) |
| code_b | input | 8 | Second control code (fraction of supply, 0..255) |
| enable | input | 1 | Run control; low forces the output low and parks the counter |
| force_high | input | 1 | Holds the output high while enabled |
| pwm_out | output | 1 | Fan-drive PWM output |
| period_start | output | 1 | One-clock strobe at the start of each period |

## Verification
The bench sweeps every selected code across the window, with the larger value on `code_a` and then on `code_b`. It measures the high count of each full period against the window formula. A wrong floor or ceiling constant, a rounding error in the scaling, or a reversed max selector would show up as an off-by-some high count near 77, near 179 or in the mirrored sweep. A design that takes a code change at once rather than at the wrap would lengthen the period in which the code rises mid-way. A design that let force override enable would drive the fan while disabled. A counter that did not wait for `tick` would give a period of 766 or 256 clocks instead of 768 under a one-in-three tick, and the high count would change with it. The first period after enable is timed to its 256th tick, and the output that follows a force release is checked to the clock.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  // Default geometry of the fan PWM generator
  localparam int CODE_W_DEF  = 8;    // control code width
  localparam int CNT_W_DEF   = 8;    // period counter width (2**CNT_W ticks)
  localparam int FLOOR_DEF   = 77;   // code giving 0 % duty
  localparam int CEIL_DEF    = 179;  // code giving 100 % duty
  localparam int SYNC_STAGES = 2;    // reset release synchronizer depth
endpackage

// File: rtl/fan_rst_sync.sv
module fan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fan_max_sel.sv
module fan_max_sel #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output logic [CODE_W-1:0] code_max
);
  always_comb begin
    if (code_a >= code_b) code_max = code_a;
    else                  code_max = code_b;
  end
endmodule

// File: rtl/fan_duty_map.sv
module fan_duty_map #(
  parameter int CODE_W  = 8,
  parameter int CNT_W   = 8,
  parameter int FLOOR   = 77,
  parameter int CEIL    = 179
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W:0]    duty
);
  localparam int DUTY_W = CNT_W + 1;
  localparam int PROD_W = CODE_W + CNT_W;
  localparam int SPAN   = CEIL - FLOOR;
  localparam int FULL   = 1 << CNT_W;

  localparam logic [CODE_W-1:0] FLOOR_V = CODE_W'(FLOOR);
  localparam logic [CODE_W-1:0] CEIL_V  = CODE_W'(CEIL);
  localparam logic [PROD_W-1:0] SPAN_V  = PROD_W'(SPAN);
  localparam logic [DUTY_W-1:0] FULL_V  = DUTY_W'(FULL);

  logic [CODE_W-1:0] diff;
  logic [PROD_W-1:0] prod;

  always_comb begin
    diff = code - FLOOR_V;
    prod = {diff, {CNT_W{1'b0}}};
    if (code <= FLOOR_V) begin
      duty = '0;
    end else if (code >= CEIL_V) begin
      duty = FULL_V;
    end else begin
      duty = DUTY_W'(prod / SPAN_V);
    end
  end
endmodule

// File: rtl/fan_period_ctr.sv
module fan_period_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      wrap  = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pwm_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int CNT_W  = CNT_W_DEF,
  parameter int FLOOR  = FLOOR_DEF,
  parameter int CEIL   = CEIL_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic              enable,
  input  logic              force_high,
  output logic              pwm_out,
  output logic              period_start
);
  localparam int DUTY_W = CNT_W + 1;

  logic              rst_sync_n;
  logic [CODE_W-1:0] code_max;
  logic [DUTY_W-1:0] duty_calc;
  logic [DUTY_W-1:0] duty_q;
  logic [DUTY_W-1:0] duty_d;
  logic              duty_en;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic              wrap;
  logic              pwm_d;
  logic              pwm_q;
  logic              strobe_q;

  fan_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fan_max_sel #(.CODE_W(CODE_W)) u_max (
    .code_a   (code_a),
    .code_b   (code_b),
    .code_max (code_max)
  );

  fan_duty_map #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W),
    .FLOOR  (FLOOR),
    .CEIL   (CEIL)
  ) u_map (
    .code (code_max),
    .duty (duty_calc)
  );

  fan_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (enable),
    .tick  (tick),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d),
    .wrap  (wrap)
  );

  // Next-state: the duty is captured at a wrap, or continuously while parked
  always_comb begin
    duty_en = wrap || !enable;
    duty_d  = duty_en ? duty_calc : duty_q;
    pwm_d   = enable && (force_high || ({1'b0, cnt_d} < duty_d));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      duty_q <= '0;
    end else if (duty_en) begin
      duty_q <= duty_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pwm_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      pwm_q    <= pwm_d;
      strobe_q <= wrap;
    end
  end

  assign pwm_out      = pwm_q;
  assign period_start = strobe_q;
endmodule

// File: rtl/fan_pwm_chk.sv
module fan_pwm_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             enable,
  input logic             force_high,
  input logic             pwm_out,
  input logic             period_start,
  input logic [CNT_W:0]   duty_q,
  input logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W:0] FULL_V = (CNT_W+1)'(1 << CNT_W);

  // R7: disabled block drives low, even with force asserted
  a_r7_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pwm_out);

  // R7: counter parked at zero while disabled
  a_r7_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));

  // R6: force holds the output high while enabled
  a_r6_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && force_high) |=> pwm_out);

  // R3: saturated duty leaves no low phase
  a_r3_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && duty_q == FULL_V) |-> pwm_out);

  // R2: zero duty without force keeps the output low
  a_r2_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !$past(force_high) && duty_q == '0) |-> !pwm_out);

  // R4: no tick, no counter movement
  a_r4_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !$past(tick)) |-> $stable(cnt_q));

  // R5: captured duty only moves at a period start or while parked
  a_r5_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !period_start) |-> $stable(duty_q));

  // R8: strobe follows a ticked, enabled clock and lasts one clock
  a_r8_strobe_tick: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> ($past(tick) && $past(enable)));

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);
endmodule

bind fan_pwm_gen fan_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .tick         (tick),
  .enable       (enable),
  .force_high   (force_high),
  .pwm_out      (pwm_out),
  .period_start (period_start),
  .duty_q       (duty_q),
  .cnt_q        (cnt_q)
);

// File: tb/tb_fan_pwm_gen.sv
`timescale 1ns/1ps
module tb_fan_pwm_gen;
  logic       clk;
  logic       rst_n;
  logic       tick;
  logic [7:0] code_a;
  logic [7:0] code_b;
  logic       enable;
  logic       force_high;
  logic       pwm_out;
  logic       period_start;

  int total;
  int bad;
  int pending;

  fan_pwm_gen dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .code_a       (code_a),
    .code_b       (code_b),
    .enable       (enable),
    .force_high   (force_high),
    .pwm_out      (pwm_out),
    .period_start (period_start)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int ref_duty(input int c);
    if (c <= 77)  return 0;
    if (c >= 179) return 256;
    return ((c - 77) * 256) / 102;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a >= b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // Called on the negedge that shows a period start; measures one full
  // period of 256 clocks (tick every clock) and ends on the next start.
  task automatic run_period(input int exp_hi, input string tag,
                            input bit mid_en, input int mid_a);
    int hi;
    int strobe_err;
    hi = 0;
    strobe_err = 0;
    for (int k = 0; k < 256; k++) begin
      if (k > 0) @(negedge clk);
      if (mid_en && k == 100) begin
        code_a = 8'(mid_a);
        code_b = 8'd0;
      end
      hi += int'(pwm_out);
      if (period_start != (k == 0)) strobe_err++;
    end
    @(negedge clk);
    chk(hi == exp_hi, tag, hi, exp_hi);
    chk(strobe_err == 0 && period_start,
        {"R8 strobe once per period, ", tag}, strobe_err, 0);
  endtask

  initial begin
    #1_800_000;
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi;
    int first;
    total = 0;
    bad = 0;
    rst_n = 1'b0;
    tick = 1'b1;
    code_a = 8'd0;
    code_b = 8'd0;
    enable = 1'b0;
    force_high = 1'b0;

    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b0, "R9 pwm_out in reset", int'(pwm_out), 0);
    chk(period_start == 1'b0, "R9 period_start in reset", int'(period_start), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7: disabled, forced, high code: output stays low
    force_high = 1'b1;
    code_a = 8'd200;
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b0, "R7 disable dominates force", int'(pwm_out), 0);
    force_high = 1'b0;
    code_a = 8'd128;
    repeat (2) @(negedge clk);

    // R7: first strobe 256 ticks after enable, duty captured while parked
    enable = 1'b1;
    hi = 0;
    first = -1;
    for (int k = 1; k <= 256; k++) begin
      @(negedge clk);
      hi += int'(pwm_out);
      if (period_start && first < 0) first = k;
    end
    chk(first == 256, "R7 first period_start after enable", first, 256);
    chk(hi == 128, "R7 first period uses parked duty", hi, 128);
    pending = 128;

    // R5: a mid-period code rise leaves this period unchanged
    run_period(pending, "R5 mid-period change ignored", 1'b1, 255);
    pending = ref_duty(255);

    // R2/R3 sweep with the larger code on code_a
    for (int v = 0; v < 256; v++) begin
      code_a = 8'(v);
      code_b = 8'(v >> 1);
      run_period(pending, $sformatf("R2/R3 sweep a, prev duty %0d", pending), 1'b0, 0);
      pending = ref_duty(max2(v, v >> 1));
    end

    // R1 sweep with the larger code on code_b, plus equal codes
    for (int v = 60; v <= 190; v++) begin
      code_a = 8'(v >> 1);
      code_b = 8'(v);
      run_period(pending, $sformatf("R1 sweep b, prev duty %0d", pending), 1'b0, 0);
      pending = ref_duty(v);
    end
    code_a = 8'd140;
    code_b = 8'd140;
    run_period(pending, "R1 sweep b last", 1'b0, 0);
    pending = ref_duty(140);
    code_a = 8'd0;
    code_b = 8'd0;
    run_period(pending, "R1 equal codes", 1'b0, 0);
    pending = 0;

    // R6: force over a zero-duty period, then release
    run_period(pending, "R2 zero duty before force", 1'b0, 0);
    force_high = 1'b1;
    run_period(255, "R6 force high over zero duty", 1'b0, 0);
    force_high = 1'b0;
    run_period(1, "R6 release one clock later", 1'b0, 0);

    // R4: one tick in three; transition period, then a full 768-clock period
    code_a = 8'd128;
    first = -1;
    hi = 0;
    for (int k = 0; k <= 1534; k++) begin
      if (k > 0) @(negedge clk);
      tick = (k % 3 == 0);
      if (k > 0 && period_start && first < 0) first = k;
      if (k >= 766 && k < 1534) hi += int'(pwm_out);
      if (k == 1534) chk(period_start == 1'b1, "R4 strobe after 256 slow ticks",
                         int'(period_start), 1);
    end
    chk(first == 766, "R4 transition period length", first, 766);
    chk(hi == 3 * ref_duty(128), "R4 high clocks scale with tick rate", hi, 3 * ref_duty(128));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule